// File: doc/BRIEF.md
# Single-Precision Compare, Sign-Injection and Classify Unit

This unit handles the single-precision floating-point operations that never round: minimum, maximum, the three comparisons (equal, less-than, less-or-equal), the three sign-injection forms and classification. A caller presents two 32-bit operands and a 4-bit operation code. One clock edge later the unit returns a 32-bit result and an invalid-operation flag. Comparisons and classification return integer values in the low bits of the result, with the other bits cleared.

NaN handling is what sets the operations apart. Minimum and maximum return the canonical NaN when a NaN has to come out. If exactly one operand is a quiet NaN, they pass the other operand through unchanged. Equality is a quiet comparison, while the two ordered comparisons are signaling. Sign injection works on raw bit patterns and never raises a flag. Classification returns a one-hot mask of ten classes.

Top module: `fpcs_unit`

## Requirements
- R1: While reset is low, result and invalid are 0. The outputs are registered: the values for operands and operation code applied before a rising edge appear after that edge. A new operation can be issued every cycle.
- R2: Operation codes are: 0 minimum, 1 maximum, 2 equal, 3 less-than, 4 less-or-equal, 5 sign-copy, 6 sign-copy-inverted, 7 sign-xor, 8 classify. For minimum and maximum with no NaN operand, the result is the numerically smaller (or larger) operand, and -0 (0x80000000) counts as smaller than +0.
- R3: For minimum and maximum, the result is the canonical NaN 0x7fc00000 if either operand is a signaling NaN or both are quiet NaNs. If exactly one operand is a quiet NaN, the result is the other operand, unchanged. No other NaN pattern is ever returned.
- R4: For minimum and maximum, invalid is 1 exactly when at least one operand is a signaling NaN.
- R5: Equal returns 1 in bit 0 when the operands are numerically equal, so +0 equals -0. It returns 0 when either operand is NaN. Invalid is 1 only when an operand is a signaling NaN.
- R6: Less-than and less-or-equal return 1 in bit 0 when the relation holds and 0 when either operand is NaN. Invalid is 1 whenever either operand is any NaN.
- R7: Sign injection copies bits 30..0 from operand A. The result sign is B's sign for code 5, its inverse for code 6, and A's sign XOR B's sign for code 7. NaN payloads are kept as they are.
- R8: Sign injection never sets invalid.
- R9: Classify returns a mask in bits 9..0 with exactly one bit set and bits 31..10 cleared. The bits are: 0 -inf, 1 negative normal, 2 negative subnormal, 3 -0, 4 +0, 5 positive subnormal, 6 positive normal, 7 +inf, 8 signaling NaN, 9 quiet NaN. A NaN is quiet when fraction bit 22 is set, and signaling when bit 22 is clear and the fraction is nonzero. Classify never sets invalid.
- R10: Operation codes 9 to 15 return result 0 with invalid 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code (see R2) |
| src_a | input | 32 | Operand A |
| src_b | input | 32 | Operand B |
| result | output | 32 | Registered result |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
The bench drives every ordered pair from a set of special values through all sixteen operation codes. The set covers both zeros, the smallest and largest subnormals and normals, both infinities, and quiet and signaling NaNs of both signs with different payloads. It compares each result against a model that orders values by mapping each one to a signed integer key. If zero signs are treated as equal for minimum, the bench sees the wrong zero come back. If NaNs are forwarded or their payloads kept for minimum and maximum, it sees a non-canonical NaN. If equality is made signaling, or the ordered comparisons quiet, the invalid flag is wrong on quiet-NaN pairs. If sign injection canonicalizes, the result loses the signaling payload, and if the quiet-bit test is reversed, classification puts NaNs in the wrong class.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MAG_W   = WORD_W - 1;
  localparam int CLASS_W = 10;
  localparam int OP_W    = 4;

  localparam logic [WORD_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [OP_W-1:0] {
    OP_MIN   = 4'd0,
    OP_MAX   = 4'd1,
    OP_EQ    = 4'd2,
    OP_LT    = 4'd3,
    OP_LE    = 4'd4,
    OP_SGNJ  = 4'd5,
    OP_SGNJN = 4'd6,
    OP_SGNJX = 4'd7,
    OP_CLASS = 4'd8
  } fpcs_op_e;

  typedef struct packed {
    logic sign;
    logic inf;
    logic nan;
    logic snan;
    logic zero;
    logic sub;
    logic norm;
  } fp_kind_t;

  // Split an encoding into its value category.
  function automatic fp_kind_t fp_decode(input logic [WORD_W-1:0] v);
    fp_kind_t k;
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    logic e_max, e_zero, f_zero;
    e      = v[WORD_W-2 -: EXP_W];
    f      = v[FRAC_W-1:0];
    e_max  = &e;
    e_zero = ~|e;
    f_zero = ~|f;
    k.sign = v[WORD_W-1];
    k.inf  = e_max & f_zero;
    k.nan  = e_max & ~f_zero;
    k.snan = e_max & ~f_zero & ~f[FRAC_W-1];
    k.zero = e_zero & f_zero;
    k.sub  = e_zero & ~f_zero;
    k.norm = ~e_max & ~e_zero;
    return k;
  endfunction

  // Same-sign ordering on magnitude: larger magnitude is smaller when negative.
  function automatic logic mag_before(input logic neg,
                                      input logic [MAG_W-1:0] ma,
                                      input logic [MAG_W-1:0] mb);
    return neg ? (ma > mb) : (ma < mb);
  endfunction

  // Numeric less-than for non-NaN values; both zeros compare equal.
  function automatic logic fp_less(input logic [WORD_W-1:0] a,
                                   input logic [WORD_W-1:0] b,
                                   input logic both_zero);
    if (both_zero)                      return 1'b0;
    if (a[WORD_W-1] != b[WORD_W-1])     return a[WORD_W-1];
    return mag_before(a[WORD_W-1], a[MAG_W-1:0], b[MAG_W-1:0]);
  endfunction

  // Total less-than for non-NaN values; -0 sorts below +0.
  function automatic logic fp_less_total(input logic [WORD_W-1:0] a,
                                         input logic [WORD_W-1:0] b);
    if (a[WORD_W-1] != b[WORD_W-1])     return a[WORD_W-1];
    return mag_before(a[WORD_W-1], a[MAG_W-1:0], b[MAG_W-1:0]);
  endfunction
endpackage

// File: rtl/fpcs_decode.sv
module fpcs_decode
  import fpcs_pkg::*;
#(
  parameter int N_OPS = 2
) (
  input  logic [N_OPS-1:0][WORD_W-1:0] ops,
  output fp_kind_t [N_OPS-1:0]         kinds
);
  for (genvar i = 0; i < N_OPS; i++) begin : g_dec
    assign kinds[i] = fp_decode(ops[i]);
  end
endmodule

// File: rtl/fpcs_order.sv
module fpcs_order
  import fpcs_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              a_zero,
  input  logic              b_zero,
  output logic              num_eq,
  output logic              num_lt,
  output logic              tot_lt
);
  logic both_zero;
  assign both_zero = a_zero & b_zero;
  assign num_eq    = (a == b) | both_zero;
  assign num_lt    = fp_less(a, b, both_zero);
  assign tot_lt    = fp_less_total(a, b);
endmodule

// File: rtl/fpcs_class.sv
module fpcs_class
  import fpcs_pkg::*;
(
  input  fp_kind_t           k,
  output logic [CLASS_W-1:0] mask
);
  logic pos;
  assign pos = ~k.sign;
  always_comb begin
    mask    = '0;
    mask[0] = k.sign & k.inf;
    mask[1] = k.sign & k.norm;
    mask[2] = k.sign & k.sub;
    mask[3] = k.sign & k.zero;
    mask[4] = pos & k.zero;
    mask[5] = pos & k.sub;
    mask[6] = pos & k.norm;
    mask[7] = pos & k.inf;
    mask[8] = k.snan;
    mask[9] = k.nan & ~k.snan;
  end
endmodule

// File: rtl/fpcs_unit.sv
module fpcs_unit
  import fpcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  output logic [WORD_W-1:0] result,
  output logic              invalid
);
  fpcs_op_e op_e;
  assign op_e = fpcs_op_e'(op_sel);

  // Operand categories
  fp_kind_t [1:0] kinds;
  fp_kind_t       ka, kb;
  fpcs_decode #(.N_OPS(2)) u_dec (
    .ops   ({src_b, src_a}),
    .kinds (kinds)
  );
  assign ka = kinds[0];
  assign kb = kinds[1];

  // Named events used by the selection logic and the assertions
  logic any_nan, any_snan, both_nan;
  assign any_nan  = ka.nan | kb.nan;
  assign any_snan = ka.snan | kb.snan;
  assign both_nan = ka.nan & kb.nan;

  logic num_eq, num_lt, tot_lt;
  fpcs_order u_ord (
    .a      (src_a),
    .b      (src_b),
    .a_zero (ka.zero),
    .b_zero (kb.zero),
    .num_eq (num_eq),
    .num_lt (num_lt),
    .tot_lt (tot_lt)
  );

  logic [CLASS_W-1:0] class_mask;
  fpcs_class u_cls (
    .k    (ka),
    .mask (class_mask)
  );

  logic              is_minmax, is_sgnj, is_cmp;
  logic [WORD_W-1:0] mm_pick;
  assign is_minmax = (op_e == OP_MIN) | (op_e == OP_MAX);
  assign is_sgnj   = (op_e == OP_SGNJ) | (op_e == OP_SGNJN) | (op_e == OP_SGNJX);
  assign is_cmp    = (op_e == OP_EQ) | (op_e == OP_LT) | (op_e == OP_LE);

  always_comb begin
    if (any_snan | both_nan)       mm_pick = CANON_NAN;
    else if (ka.nan)               mm_pick = src_b;
    else if (kb.nan)               mm_pick = src_a;
    else if (op_e == OP_MIN)       mm_pick = tot_lt ? src_a : src_b;
    else                           mm_pick = tot_lt ? src_b : src_a;
  end

  logic [WORD_W-1:0] res_d;
  logic              nv_d;
  always_comb begin
    res_d = '0;
    nv_d  = 1'b0;
    case (op_e)
      OP_MIN, OP_MAX: begin
        res_d = mm_pick;
        nv_d  = any_snan;
      end
      OP_EQ: begin
        res_d[0] = ~any_nan & num_eq;
        nv_d     = any_snan;
      end
      OP_LT: begin
        res_d[0] = ~any_nan & num_lt;
        nv_d     = any_nan;
      end
      OP_LE: begin
        res_d[0] = ~any_nan & (num_lt | num_eq);
        nv_d     = any_nan;
      end
      OP_SGNJ:  res_d = {kb.sign,            src_a[MAG_W-1:0]};
      OP_SGNJN: res_d = {~kb.sign,           src_a[MAG_W-1:0]};
      OP_SGNJX: res_d = {ka.sign ^ kb.sign,  src_a[MAG_W-1:0]};
      OP_CLASS: res_d[CLASS_W-1:0] = class_mask;
      default: begin
        res_d = '0;
        nv_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      invalid <= 1'b0;
    end else begin
      result  <= res_d;
      invalid <= nv_d;
    end
  end

  // Assertions
  logic res_is_nan;
  assign res_is_nan = (&result[WORD_W-2 -: EXP_W]) & (|result[FRAC_W-1:0]);

  assert_minmax_canon_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_minmax |=> (!res_is_nan || result == CANON_NAN));

  assert_minmax_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_minmax |=> (invalid == $past(any_snan)));

  assert_eq_nan_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_EQ && any_nan) |=> (result == '0));

  assert_order_nan_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_e == OP_LT || op_e == OP_LE) && any_nan) |=> (invalid && result == '0));

  assert_cmp_boolean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> (result[WORD_W-1:1] == '0));

  assert_sgnj_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_sgnj |=> !invalid);

  assert_sgnj_body_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_sgnj |=> (result[MAG_W-1:0] == $past(src_a[MAG_W-1:0])));

  assert_class_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_CLASS) |=> ($countones(result[CLASS_W-1:0]) == 1 &&
                            result[WORD_W-1:CLASS_W] == '0 && !invalid));

  assert_decode_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({ka.inf, ka.nan, ka.zero, ka.sub, ka.norm}) == 1 &&
     $countones({kb.inf, kb.nan, kb.zero, kb.sub, kb.norm}) == 1 &&
     (!kb.snan || kb.nan) && (kb.sign == src_b[WORD_W-1])));

  assert_spare_ops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 4'd8) |=> (result == '0 && !invalid));
endmodule

// File: tb/tb_fpcs_unit.sv
module tb_fpcs_unit;
  logic        clk    = 1'b0;
  logic        rst_n  = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [31:0] src_a  = 32'd0;
  logic [31:0] src_b  = 32'd0;
  logic [31:0] result;
  logic        invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  fpcs_unit dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .src_a   (src_a),
    .src_b   (src_b),
    .result  (result),
    .invalid (invalid)
  );

  localparam int NV = 22;

  function automatic logic [31:0] pick(input int i);
    case (i)
      0:  return 32'h0000_0000;  // +0
      1:  return 32'h8000_0000;  // -0
      2:  return 32'h0000_0001;  // +min subnormal
      3:  return 32'h8000_0001;
      4:  return 32'h007f_ffff;  // +max subnormal
      5:  return 32'h807f_ffff;
      6:  return 32'h0080_0000;  // +min normal
      7:  return 32'h8080_0000;
      8:  return 32'h3f80_0000;  // +1
      9:  return 32'hbf80_0000;  // -1
      10: return 32'h4000_0000;  // +2
      11: return 32'hc000_0000;
      12: return 32'h7f7f_ffff;  // +max normal
      13: return 32'hff7f_ffff;
      14: return 32'h7f80_0000;  // +inf
      15: return 32'hff80_0000;  // -inf
      16: return 32'h7fc0_0000;  // canonical quiet NaN
      17: return 32'hffc1_2345;  // negative quiet NaN, payload
      18: return 32'h7f80_0001;  // signaling NaN
      19: return 32'hffa0_0000;  // negative signaling NaN
      20: return 32'h3f80_0001;  // 1 + ulp
      default: return 32'h4049_0fdb;
    endcase
  endfunction

  function automatic bit m_nan(input logic [31:0] x);
    return (x[30:23] == 8'd255) && (x[22:0] != 23'd0);
  endfunction
  function automatic bit m_snan(input logic [31:0] x);
    return m_nan(x) && (x[22] == 1'b0);
  endfunction
  // Numeric key: both zeros map to 0.
  function automatic longint k_num(input logic [31:0] x);
    longint m;
    m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction
  // Total key: -0 sits one below +0.
  function automatic longint k_tot(input logic [31:0] x);
    longint m;
    m = longint'(x[30:0]);
    return x[31] ? (-m - 1) : m;
  endfunction
  function automatic logic [9:0] m_class(input logic [31:0] x);
    int idx;
    int e;
    e = int'(x[30:23]);
    if (m_nan(x))            idx = x[22] ? 9 : 8;
    else if (e == 255)       idx = x[31] ? 0 : 7;
    else if (e != 0)         idx = x[31] ? 1 : 6;
    else if (x[22:0] != 0)   idx = x[31] ? 2 : 5;
    else                     idx = x[31] ? 3 : 4;
    return 10'd1 << idx;
  endfunction

  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic f,
                       output string rtag, output string ftag);
    bit na, nb, sa, sb;
    na = m_nan(a); nb = m_nan(b); sa = m_snan(a); sb = m_snan(b);
    r = 32'd0; f = 1'b0;
    case (op)
      0, 1: begin
        ftag = "R4";
        rtag = (na || nb) ? "R3" : "R2";
        f = sa || sb;
        if (sa || sb || (na && nb)) r = 32'h7fc0_0000;
        else if (na)                r = b;
        else if (nb)                r = a;
        else if (op == 0)           r = (k_tot(a) <= k_tot(b)) ? a : b;
        else                        r = (k_tot(a) >= k_tot(b)) ? a : b;
      end
      2: begin
        rtag = "R5"; ftag = "R5";
        f = sa || sb;
        r = {31'd0, !(na || nb) && (k_num(a) == k_num(b))};
      end
      3: begin
        rtag = "R6"; ftag = "R6";
        f = na || nb;
        r = {31'd0, !(na || nb) && (k_num(a) < k_num(b))};
      end
      4: begin
        rtag = "R6"; ftag = "R6";
        f = na || nb;
        r = {31'd0, !(na || nb) && (k_num(a) <= k_num(b))};
      end
      5, 6, 7: begin
        rtag = "R7"; ftag = "R8";
        r = a;
        if (op == 5)      r[31] = b[31];
        else if (op == 6) r[31] = !b[31];
        else              r[31] = (a[31] != b[31]);
      end
      8: begin
        rtag = "R9"; ftag = "R9";
        r = {22'd0, m_class(a)};
      end
      default: begin
        rtag = "R10"; ftag = "R10";
      end
    endcase
  endtask

  task automatic check_out(input logic [31:0] er, input logic ef,
                           input string rtag, input string ftag,
                           input int op, input logic [31:0] a, input logic [31:0] b);
    checks++;
    if (result !== er) begin
      fails++;
      $display("FAIL %s result op=%0d a=%h b=%h actual=%h expected=%h",
               rtag, op, a, b, result, er);
    end
    checks++;
    if (invalid !== ef) begin
      fails++;
      $display("FAIL %s invalid op=%0d a=%h b=%h actual=%b expected=%b",
               ftag, op, a, b, invalid, ef);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pr, er;
    logic        pf, ef;
    string       prt, pft, ert, eft;
    int          pop;
    logic [31:0] pa, pb;
    bit          pending;

    // R1: reset holds outputs at zero even with a live operation on the inputs
    op_sel = 4'd8; src_a = 32'hff80_0000; src_b = 32'd0;
    repeat (3) @(negedge clk);
    check_out(32'd0, 1'b0, "R1", "R1", 8, src_a, src_b);
    @(negedge clk);
    rst_n = 1'b1;

    // Sweep: one new operation per cycle, each checked one cycle later (R1)
    pending = 1'b0;
    pop = 0; pa = 0; pb = 0; pr = 0; pf = 0; prt = ""; pft = "";
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < NV; i++) begin
        for (int j = 0; j < NV; j++) begin
          @(negedge clk);
          if (pending) check_out(pr, pf, prt, pft, pop, pa, pb);
          op_sel = 4'(op);
          src_a  = pick(i);
          src_b  = pick(j);
          model(op, src_a, src_b, er, ef, ert, eft);
          pr = er; pf = ef; prt = ert; pft = eft;
          pop = op; pa = src_a; pb = src_b;
          pending = 1'b1;
        end
      end
    end
    @(negedge clk);
    if (pending) check_out(pr, pf, prt, pft, pop, pa, pb);

    // R1: asserting reset again clears the outputs
    op_sel = 4'd5; src_a = 32'h7f80_0001; src_b = 32'hffff_ffff;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_out(32'd0, 1'b0, "R1", "R1", 5, src_a, src_b);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule